// File: doc/BRIEF.md
# Four-Plane Straight-Line Track Finder

This block finds straight tracks for one event in a planar silicon telescope. Strip hits from the first four detector planes arrive one per cycle. Each hit is tagged with its projection (x or y) and its plane. Inside each plane the strips are sorted in ascending order. Each projection has its own finder. That finder merges runs of neighbouring strips into clusters and stores them. When the event ends, it walks through every choice of one cluster per plane, at one choice per clock.

A candidate line is defined by its plane-1 and plane-4 clusters. It is kept when the plane-2 and plane-3 clusters each lie within one strip pitch of that line, and when the line reaches the target plane (z = 0) within 1 mm of the beam axis. Strip 0 sits on the beam axis. Every kept track is emitted with its slope and its intercept at z = 0. A small decision stage collects both projections. It reports the two track counts, an error flag and a pass flag for the event.

The geometry defaults are a 50 µm pitch, 3.8 cm between neighbouring planes, and the target 6 cm upstream of plane 1. All of these are parameters. The arithmetic is fixed point with constants worked out at elaboration, so the block needs no divider.

Top module: `quad_plane_tracker`

## Requirements
- R1: In each plane of each view, a hit whose strip is exactly one above the previous hit in that plane extends the current cluster. Any other hit closes the current cluster and starts a new one. A cluster's position is first strip plus last strip, which is its centre in half-strip units.
- R2: After evt_end, combinations are tried one per clock. The plane-1 cluster index is the slowest to advance and the plane-4 index is the fastest. Clusters are indexed in arrival order. The k-th combination (k from 0), if accepted, is shown on the view's track port for exactly one cycle, k+1 cycles after the clock that sampled evt_end. x_ntrk and y_ntrk give the number of accepted combinations in each view.
- R3: Let u1..u4 be the positions on planes 1 to 4. A combination passes the residual test only if |3·u2 − (2·u1 + u4)| ≤ 6 and |3·u3 − (u1 + 2·u4)| ≤ 6. With the defaults this means each inner cluster lies within one pitch of the line.
- R4: The intercept is u1·65536 − 34493·(u4 − u1), in half-strips scaled by 2^16. A combination is accepted only if |intercept| < 40·65536, which is 1 mm.
- R5: The slope is 575·(u4 − u1), in half-strips per millimetre scaled by 2^16.
- R6: A view with any of its four planes empty reports zero tracks.
- R7: A view in which any plane collects more than 4 clusters is aborted. It emits no tracks and reports a count of zero, evt_error is set, and the event fails.
- R8: evt_pass is 1 only when x_ntrk ≥ 4, y_ntrk ≥ 4 and evt_error is 0.
- R9: Let N be the number of combinations in a view (the product of its four cluster counts), with N = 1 for a view that aborts or has an empty plane. evt_done pulses for one cycle, max(Nx, Ny) + 2 cycles after the clock that sampled evt_end. The counts and flags are valid from that cycle and hold until the next evt_done.
- R10: After reset, evt_done, evt_pass, evt_error, both counts and both track strobes are 0.
- R11: Hits with hit_view = 0 reach only the x finder. Hits with hit_view = 1 reach only the y finder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_view | input | 1 | Projection of the hit: 0 = x, 1 = y |
| hit_plane | input | 2 | Plane of the hit, 0 to 3 for planes 1 to 4 |
| hit_strip | input | STRIP_W | Strip address, counted from the beam axis |
| evt_end | input | 1 | All hits of the event have been delivered |
| trk_x_valid | output | 1 | An accepted x track is on the x track outputs |
| trk_x_slope | output | FX_W | Slope of the x track |
| trk_x_icpt | output | FX_W | Intercept of the x track at z = 0 |
| trk_y_valid | output | 1 | An accepted y track is on the y track outputs |
| trk_y_slope | output | FX_W | Slope of the y track |
| trk_y_icpt | output | FX_W | Intercept of the y track at z = 0 |
| evt_done | output | 1 | The event decision is ready (one-cycle pulse) |
| evt_pass | output | 1 | The event passes the track-multiplicity test |
| evt_error | output | 1 | A cluster store overflowed in either view |
| x_ntrk | output | CNT_W | Accepted tracks in x |
| y_ntrk | output | CNT_W | Accepted tracks in y |

## Verification
The assertions assume that the input side follows the event protocol:
- Strips within one plane of one view strictly increase.
- evt_end never coincides with hit_valid.
- No hit and no evt_end arrives while a finder is searching or finishing.

The bench meets these conditions by construction. It sorts and de-duplicates each plane's strip list before sending it, and it interleaves the eight lists round-robin. It raises evt_end alone, in a cycle of its own, and it waits for evt_done before it starts the next event. Cluster counts above the store depth are still produced on purpose, because the overflow abort must be exercised.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

    localparam int NPLANE = 4;
    localparam int PL_W   = 2;
    localparam int FX_W   = 40;

    typedef logic signed [FX_W-1:0] fx_t;

    typedef struct packed {
        fx_t slope;
        fx_t icpt;
    } track_t;

    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_SEARCH  = 2'd1,
        S_FINISH  = 2'd2
    } vstate_t;

    // rounded num * 2^frac / den, evaluated at elaboration
    function automatic longint ratio_fx(input longint num, input longint den, input int frac);
        return ((num <<< frac) + den / 2) / den;
    endfunction

    function automatic fx_t fx_abs(input fx_t v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/qpt_cluster.sv
module qpt_cluster #(
    parameter int STRIP_W = 10,
    parameter int MAX_CL  = 4,
    localparam int POS_W  = STRIP_W + 1,
    localparam int CL_CW  = $clog2(MAX_CL + 1),
    localparam int IDX_W  = (MAX_CL > 1) ? $clog2(MAX_CL) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               hit_en,
    input  logic [STRIP_W-1:0] strip,
    input  logic               flush,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [POS_W-1:0]   rd_pos,
    output logic [CL_CW-1:0]   count,
    output logic               ovf
);
    logic [STRIP_W-1:0] first_s, last_s;
    logic               run_open;
    logic [POS_W-1:0]   store [MAX_CL];
    logic [POS_W-1:0]   run_pos;
    logic               adjacent;

    assign run_pos  = {1'b0, first_s} + {1'b0, last_s};
    assign adjacent = run_open && ({1'b0, strip} == ({1'b0, last_s} + 1'b1));
    assign rd_pos   = store[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_open <= 1'b0;
            count    <= '0;
            ovf      <= 1'b0;
            first_s  <= '0;
            last_s   <= '0;
        end else if (hit_en) begin
            if (adjacent) begin
                last_s <= strip;
            end else begin
                if (run_open) begin
                    if (count == CL_CW'(MAX_CL)) ovf <= 1'b1;
                    else begin
                        store[count[IDX_W-1:0]] <= run_pos;
                        count <= count + 1'b1;
                    end
                end
                first_s  <= strip;
                last_s   <= strip;
                run_open <= 1'b1;
            end
        end else if (flush && run_open) begin
            if (count == CL_CW'(MAX_CL)) ovf <= 1'b1;
            else begin
                store[count[IDX_W-1:0]] <= run_pos;
                count <= count + 1'b1;
            end
            run_open <= 1'b0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CL_CW'(MAX_CL)); // R7
    AST_SORTED_STRIPS: assert property (@(posedge clk) disable iff (rst)
        (hit_en && run_open) |-> (strip > last_s)); // R1

endmodule

// File: rtl/qpt_geom.sv
module qpt_geom import qpt_pkg::*; #(
    parameter int STRIP_W  = 10,
    parameter int PITCH_UM = 50,
    parameter int GAP_UM   = 38000,
    parameter int TGT_UM   = 60000,
    parameter int WIN_UM   = 50,
    parameter int ACC_UM   = 1000,
    parameter int FRAC     = 16,
    localparam int POS_W   = STRIP_W + 1
) (
    input  logic [POS_W-1:0] u1,
    input  logic [POS_W-1:0] u2,
    input  logic [POS_W-1:0] u3,
    input  logic [POS_W-1:0] u4,
    output logic             accept,
    output track_t           trk
);
    localparam fx_t K_ICPT  = fx_t'(ratio_fx(longint'(TGT_UM), 3 * longint'(GAP_UM), FRAC));
    localparam fx_t K_SLOPE = fx_t'(ratio_fx(1000, 3 * longint'(GAP_UM), FRAC));
    localparam int  WIN_HS  = (2 * WIN_UM) / PITCH_UM;
    localparam fx_t RES_LIM = fx_t'(3 * WIN_HS);
    localparam fx_t ACC_LIM = fx_t'(longint'((2 * ACC_UM) / PITCH_UM) <<< FRAC);

    fx_t a1, a2, a3, a4, d, r2, r3, icpt;

    always_comb begin
        a1   = {{(FX_W-POS_W){1'b0}}, u1};
        a2   = {{(FX_W-POS_W){1'b0}}, u2};
        a3   = {{(FX_W-POS_W){1'b0}}, u3};
        a4   = {{(FX_W-POS_W){1'b0}}, u4};
        d    = a4 - a1;
        r2   = (a2 + a2 + a2) - (a1 + a1 + a4);
        r3   = (a3 + a3 + a3) - (a1 + a4 + a4);
        icpt = (a1 <<< FRAC) - K_ICPT * d;
        trk.slope = K_SLOPE * d;
        trk.icpt  = icpt;
        accept = (fx_abs(r2) <= RES_LIM) && (fx_abs(r3) <= RES_LIM) && (fx_abs(icpt) < ACC_LIM);
    end

endmodule

// File: rtl/qpt_view.sv
module qpt_view import qpt_pkg::*; #(
    parameter int STRIP_W  = 10,
    parameter int MAX_CL   = 4,
    parameter int PITCH_UM = 50,
    parameter int GAP_UM   = 38000,
    parameter int TGT_UM   = 60000,
    parameter int WIN_UM   = 50,
    parameter int ACC_UM   = 1000,
    parameter int FRAC     = 16,
    localparam int POS_W   = STRIP_W + 1,
    localparam int CL_CW   = $clog2(MAX_CL + 1),
    localparam int IDX_W   = (MAX_CL > 1) ? $clog2(MAX_CL) : 1,
    localparam int CNT_W   = $clog2(MAX_CL**4 + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit_valid,
    input  logic [PL_W-1:0]    hit_plane,
    input  logic [STRIP_W-1:0] hit_strip,
    input  logic               evt_end,
    output logic               trk_valid,
    output track_t             trk,
    output logic               vdone,
    output logic [CNT_W-1:0]   vcount,
    output logic               vovf
);
    localparam fx_t ACC_LIM = fx_t'(longint'((2 * ACC_UM) / PITCH_UM) <<< FRAC);

    vstate_t            state;
    logic [IDX_W-1:0]   idx  [NPLANE];
    logic [IDX_W-1:0]   nidx [NPLANE];
    logic [CL_CW-1:0]   cnt  [NPLANE];
    logic [POS_W-1:0]   pos  [NPLANE];
    logic [NPLANE-1:0]  ovf, empty;
    logic               last_combo, abort, acc;
    logic [CNT_W-1:0]   tcount;
    track_t             gtrk;

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        qpt_cluster #(.STRIP_W(STRIP_W), .MAX_CL(MAX_CL)) u_cl (
            .clk    (clk),
            .rst    (rst),
            .clear  (state == S_FINISH),
            .hit_en (hit_valid && (hit_plane == PL_W'(p)) && (state == S_COLLECT)),
            .strip  (hit_strip),
            .flush  (evt_end && (state == S_COLLECT)),
            .rd_idx (idx[p]),
            .rd_pos (pos[p]),
            .count  (cnt[p]),
            .ovf    (ovf[p])
        );
        assign empty[p] = (cnt[p] == '0);
    end

    assign abort = (|ovf) || (|empty);

    // odometer: plane 4 index fastest, plane 1 index slowest
    always_comb begin
        logic carry;
        carry = 1'b1;
        for (int p = NPLANE - 1; p >= 0; p--) begin
            nidx[p] = idx[p];
            if (carry) begin
                if ((CL_CW'(idx[p]) + CL_CW'(1)) == cnt[p]) nidx[p] = '0;
                else begin
                    nidx[p] = idx[p] + 1'b1;
                    carry   = 1'b0;
                end
            end
        end
        last_combo = carry;
    end

    qpt_geom #(
        .STRIP_W(STRIP_W), .PITCH_UM(PITCH_UM), .GAP_UM(GAP_UM), .TGT_UM(TGT_UM),
        .WIN_UM(WIN_UM), .ACC_UM(ACC_UM), .FRAC(FRAC)
    ) u_geom (
        .u1(pos[0]), .u2(pos[1]), .u3(pos[2]), .u4(pos[3]),
        .accept(acc), .trk(gtrk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_COLLECT;
            trk_valid <= 1'b0;
            trk       <= '0;
            vdone     <= 1'b0;
            vcount    <= '0;
            vovf      <= 1'b0;
            tcount    <= '0;
            for (int p = 0; p < NPLANE; p++) idx[p] <= '0;
        end else begin
            trk_valid <= 1'b0;
            vdone     <= 1'b0;
            case (state)
                S_COLLECT: if (evt_end) begin
                    state  <= S_SEARCH;
                    tcount <= '0;
                    for (int p = 0; p < NPLANE; p++) idx[p] <= '0;
                end
                S_SEARCH: if (abort) begin
                    state <= S_FINISH;
                end else begin
                    trk_valid <= acc;
                    trk       <= gtrk;
                    if (acc) tcount <= tcount + 1'b1;
                    for (int p = 0; p < NPLANE; p++) idx[p] <= nidx[p];
                    if (last_combo) state <= S_FINISH;
                end
                S_FINISH: begin
                    vdone  <= 1'b1;
                    vcount <= tcount;
                    vovf   <= |ovf;
                    state  <= S_COLLECT;
                end
                default: state <= S_COLLECT;
            endcase
        end
    end

    AST_QUIET_SEARCH: assert property (@(posedge clk) disable iff (rst)
        (state != S_COLLECT) |-> (!hit_valid && !evt_end)); // R9
    AST_TRK_FROM_SEARCH: assert property (@(posedge clk) disable iff (rst)
        trk_valid |-> ($past(state) == S_SEARCH)); // R2
    AST_TRK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        trk_valid |-> (fx_abs(trk.icpt) < ACC_LIM)); // R4
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (vdone && vovf) |-> (vcount == '0)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        vdone |=> !vdone); // R9

endmodule

// File: rtl/qpt_decide.sv
module qpt_decide #(
    parameter int CNT_W   = 9,
    parameter int MIN_TRK = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vdone_x,
    input  logic [CNT_W-1:0] vcount_x,
    input  logic             vovf_x,
    input  logic             vdone_y,
    input  logic [CNT_W-1:0] vcount_y,
    input  logic             vovf_y,
    output logic             evt_done,
    output logic             evt_pass,
    output logic             evt_error,
    output logic [CNT_W-1:0] x_ntrk,
    output logic [CNT_W-1:0] y_ntrk
);
    logic             got_x, got_y, ox_q, oy_q, ox_now, oy_now, both;
    logic [CNT_W-1:0] cx_q, cy_q, cx_now, cy_now;

    assign cx_now = vdone_x ? vcount_x : cx_q;
    assign cy_now = vdone_y ? vcount_y : cy_q;
    assign ox_now = vdone_x ? vovf_x : ox_q;
    assign oy_now = vdone_y ? vovf_y : oy_q;
    assign both   = (got_x || vdone_x) && (got_y || vdone_y);

    always_ff @(posedge clk) begin
        if (rst) begin
            got_x <= 1'b0; got_y <= 1'b0;
            ox_q  <= 1'b0; oy_q  <= 1'b0;
            cx_q  <= '0;   cy_q  <= '0;
            evt_done <= 1'b0; evt_pass <= 1'b0; evt_error <= 1'b0;
            x_ntrk   <= '0;   y_ntrk   <= '0;
        end else begin
            evt_done <= 1'b0;
            if (both) begin
                evt_done  <= 1'b1;
                x_ntrk    <= cx_now;
                y_ntrk    <= cy_now;
                evt_error <= ox_now || oy_now;
                evt_pass  <= !(ox_now || oy_now) && (cx_now >= CNT_W'(MIN_TRK))
                             && (cy_now >= CNT_W'(MIN_TRK));
                got_x <= 1'b0;
                got_y <= 1'b0;
            end else begin
                if (vdone_x) begin got_x <= 1'b1; cx_q <= vcount_x; ox_q <= vovf_x; end
                if (vdone_y) begin got_y <= 1'b1; cy_q <= vcount_y; oy_q <= vovf_y; end
            end
        end
    end

    AST_PASS_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        evt_pass |-> ((x_ntrk >= CNT_W'(MIN_TRK)) && (y_ntrk >= CNT_W'(MIN_TRK)))); // R8
    AST_ERROR_FAILS: assert property (@(posedge clk) disable iff (rst)
        evt_error |-> !evt_pass); // R7

endmodule

// File: rtl/quad_plane_tracker.sv
module quad_plane_tracker import qpt_pkg::*; #(
    parameter int STRIP_W  = 10,
    parameter int MAX_CL   = 4,
    parameter int PITCH_UM = 50,
    parameter int GAP_UM   = 38000,
    parameter int TGT_UM   = 60000,
    parameter int WIN_UM   = 50,
    parameter int ACC_UM   = 1000,
    parameter int FRAC     = 16,
    parameter int MIN_TRK  = 4,
    localparam int CNT_W   = $clog2(MAX_CL**4 + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit_valid,
    input  logic                   hit_view,
    input  logic [1:0]             hit_plane,
    input  logic [STRIP_W-1:0]     hit_strip,
    input  logic                   evt_end,
    output logic                   trk_x_valid,
    output logic signed [FX_W-1:0] trk_x_slope,
    output logic signed [FX_W-1:0] trk_x_icpt,
    output logic                   trk_y_valid,
    output logic signed [FX_W-1:0] trk_y_slope,
    output logic signed [FX_W-1:0] trk_y_icpt,
    output logic                   evt_done,
    output logic                   evt_pass,
    output logic                   evt_error,
    output logic [CNT_W-1:0]       x_ntrk,
    output logic [CNT_W-1:0]       y_ntrk
);
    logic             vdone [2];
    logic             vovf  [2];
    logic [CNT_W-1:0] vcnt  [2];
    logic             tval  [2];
    track_t           vtrk  [2];

    for (genvar v = 0; v < 2; v++) begin : g_view
        qpt_view #(
            .STRIP_W(STRIP_W), .MAX_CL(MAX_CL), .PITCH_UM(PITCH_UM), .GAP_UM(GAP_UM),
            .TGT_UM(TGT_UM), .WIN_UM(WIN_UM), .ACC_UM(ACC_UM), .FRAC(FRAC)
        ) u_view (
            .clk       (clk),
            .rst       (rst),
            .hit_valid (hit_valid && (hit_view == 1'(v))),
            .hit_plane (hit_plane),
            .hit_strip (hit_strip),
            .evt_end   (evt_end),
            .trk_valid (tval[v]),
            .trk       (vtrk[v]),
            .vdone     (vdone[v]),
            .vcount    (vcnt[v]),
            .vovf      (vovf[v])
        );
    end

    assign trk_x_valid = tval[0];
    assign trk_x_slope = vtrk[0].slope;
    assign trk_x_icpt  = vtrk[0].icpt;
    assign trk_y_valid = tval[1];
    assign trk_y_slope = vtrk[1].slope;
    assign trk_y_icpt  = vtrk[1].icpt;

    qpt_decide #(.CNT_W(CNT_W), .MIN_TRK(MIN_TRK)) u_decide (
        .clk      (clk),
        .rst      (rst),
        .vdone_x  (vdone[0]),
        .vcount_x (vcnt[0]),
        .vovf_x   (vovf[0]),
        .vdone_y  (vdone[1]),
        .vcount_y (vcnt[1]),
        .vovf_y   (vovf[1]),
        .evt_done (evt_done),
        .evt_pass (evt_pass),
        .evt_error(evt_error),
        .x_ntrk   (x_ntrk),
        .y_ntrk   (y_ntrk)
    );

endmodule

// File: tb/sim_quad_plane_tracker.sv
module sim_quad_plane_tracker;
    import qpt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_valid = 1'b0, hit_view = 1'b0, evt_end = 1'b0;
    logic [1:0] hit_plane = '0;
    logic [9:0] hit_strip = '0;
    logic trk_x_valid, trk_y_valid, evt_done, evt_pass, evt_error;
    logic signed [FX_W-1:0] trk_x_slope, trk_x_icpt, trk_y_slope, trk_y_icpt;
    logic [CNT_W-1:0] x_ntrk, y_ntrk;

    quad_plane_tracker u0 (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_view(hit_view),
        .hit_plane(hit_plane), .hit_strip(hit_strip), .evt_end(evt_end),
        .trk_x_valid(trk_x_valid), .trk_x_slope(trk_x_slope), .trk_x_icpt(trk_x_icpt),
        .trk_y_valid(trk_y_valid), .trk_y_slope(trk_y_slope), .trk_y_icpt(trk_y_icpt),
        .evt_done(evt_done), .evt_pass(evt_pass), .evt_error(evt_error),
        .x_ntrk(x_ntrk), .y_ntrk(y_ntrk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    int     seed   = 32'h1d2c3b4a;
    always @(posedge clk) cyc <= cyc + 1;

    int     hl [8][$];     // strip lists, index view*4+plane
    longint ex_cyc [2][$];
    longint ex_sl  [2][$];
    longint ex_ic  [2][$];

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int rnd(input int m);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return int'({1'b0, seed[30:0]} % m);
    endfunction

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic mon(input int v, input logic valid, input longint sl, input longint ic);
        logic exp;
        exp = (ex_cyc[v].size() > 0) && (ex_cyc[v][0] == cyc);
        if (valid || exp) begin
            chk($sformatf("R2 view %0d track strobe at cycle %0d", v, cyc), longint'(valid), longint'(exp));
            if (valid && exp) begin
                chk($sformatf("R5 view %0d slope", v), sl, ex_sl[v][0]);
                chk($sformatf("R4 view %0d intercept", v), ic, ex_ic[v][0]);
            end
            if (exp) begin
                void'(ex_cyc[v].pop_front());
                void'(ex_sl[v].pop_front());
                void'(ex_ic[v].pop_front());
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            mon(0, trk_x_valid, longint'(trk_x_slope), longint'(trk_x_icpt));
            mon(1, trk_y_valid, longint'(trk_y_slope), longint'(trk_y_icpt));
        end
    end

    // behavioural model of one view: clusters, combinations, acceptance
    task automatic model_view(input int v, input longint base, output int ntrk,
                              output bit ovf, output int nlat);
        int cl [4][$];
        bit empty;
        int k;
        ovf = 0; empty = 0; ntrk = 0;
        for (int p = 0; p < 4; p++) begin
            int first, last;
            first = -1; last = -1;
            foreach (hl[v*4+p][j]) begin
                int s;
                s = hl[v*4+p][j];
                if (first >= 0 && s == last + 1) last = s;
                else begin
                    if (first >= 0) cl[p].push_back(first + last);
                    first = s; last = s;
                end
            end
            if (first >= 0) cl[p].push_back(first + last);
            if (cl[p].size() > 4) ovf = 1;
            if (cl[p].size() == 0) empty = 1;
        end
        if (ovf || empty) begin
            nlat = 1;
            return;
        end
        k = 0;
        foreach (cl[0][a]) foreach (cl[1][b]) foreach (cl[2][c]) foreach (cl[3][d]) begin
            longint u1, u2, u3, u4, r2, r3, ic;
            u1 = cl[0][a]; u2 = cl[1][b]; u3 = cl[2][c]; u4 = cl[3][d];
            r2 = 3*u2 - (2*u1 + u4);
            r3 = 3*u3 - (u1 + 2*u4);
            ic = u1*65536 - 34493*(u4 - u1);
            if (labs(r2) <= 6 && labs(r3) <= 6 && labs(ic) < 40*65536) begin
                ex_cyc[v].push_back(base + k + 1);
                ex_sl[v].push_back(575*(u4 - u1));
                ex_ic[v].push_back(ic);
                ntrk++;
            end
            k++;
        end
        nlat = k;
    endtask

    task automatic add(input int v, input int p, input int s);
        hl[v*4+p].push_back(s);
    endtask

    // straight line pointing at the target: strip = m * z / 20, z in mm/10 steps
    task automatic add_line(input int v, input int m);
        for (int p = 0; p < 4; p++) add(v, p, m * (60 + 38*p) / 20);
    endtask

    task automatic run_event(input string name);
        int idx [8];
        bit more;
        int nx, ny, lx, ly, lat;
        bit ox, oy;
        longint base, seen;
        for (int i = 0; i < 8; i++) begin
            int tmp [$];
            hl[i].sort();
            tmp = {};
            foreach (hl[i][j]) if (tmp.size() == 0 || tmp[tmp.size()-1] != hl[i][j]) tmp.push_back(hl[i][j]);
            hl[i] = tmp;
            idx[i] = 0;
        end
        more = 1;
        while (more) begin
            more = 0;
            for (int i = 0; i < 8; i++) begin
                if (idx[i] < hl[i].size()) begin
                    hit_valid = 1'b1;
                    hit_view  = 1'(i / 4);
                    hit_plane = 2'(i % 4);
                    hit_strip = 10'(hl[i][idx[i]]);
                    idx[i]++;
                    more = 1;
                    @(negedge clk);
                end
            end
        end
        hit_valid = 1'b0;
        evt_end   = 1'b1;
        base = cyc + 1;
        model_view(0, base, nx, ox, lx);
        model_view(1, base, ny, oy, ly);
        lat = (lx > ly) ? lx : ly;
        @(negedge clk);
        evt_end = 1'b0;
        seen = -1;
        for (int t = 0; t < 400 && seen < 0; t++) begin
            if (evt_done) seen = cyc;
            else @(negedge clk);
        end
        chk({"R9 done timing ", name}, seen - base, longint'(lat + 2));
        chk({"R2 x count ", name}, longint'(x_ntrk), longint'(nx));
        chk({"R6 y count ", name}, longint'(y_ntrk), longint'(ny));
        chk({"R7 error flag ", name}, longint'(evt_error), longint'(ox || oy));
        chk({"R8 pass flag ", name}, longint'(evt_pass), longint'(!ox && !oy && nx >= 4 && ny >= 4));
        @(negedge clk);
        chk({"R9 done is a pulse ", name}, longint'(evt_done), 0);
        chk({"R2 no stray x tracks ", name}, longint'(ex_cyc[0].size()), 0);
        chk({"R2 no stray y tracks ", name}, longint'(ex_cyc[1].size()), 0);
        for (int i = 0; i < 8; i++) hl[i] = {};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired: got no finish exp finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 evt_done after reset", longint'(evt_done), 0);
        chk("R10 evt_pass after reset", longint'(evt_pass), 0);
        chk("R10 evt_error after reset", longint'(evt_error), 0);
        chk("R10 x_ntrk after reset", longint'(x_ntrk), 0);
        chk("R10 y_ntrk after reset", longint'(y_ntrk), 0);
        chk("R10 track strobes after reset", longint'(trk_x_valid | trk_y_valid), 0);

        // R3 R4 R8: four target-pointing lines in both views
        for (int m = 10; m <= 40; m += 10) begin add_line(0, m); add_line(1, m); end
        run_event("four lines each view");

        // R8: only three lines in y
        for (int m = 10; m <= 40; m += 10) add_line(0, m);
        for (int m = 10; m <= 30; m += 10) add_line(1, m);
        add(1, 0, 500);
        run_event("three y lines");

        // R1: multi-strip clusters centred on the line
        add(0, 0, 30); add(0, 1, 48); add(0, 1, 49); add(0, 1, 50); add(0, 2, 68); add(0, 3, 87);
        add(0, 0, 60); add(0, 1, 98); add(0, 2, 135); add(0, 2, 136); add(0, 2, 137); add(0, 3, 174);
        add_line(1, 10);
        run_event("merged clusters");

        // R3: residual just inside (r=6) and just outside (r=7)
        add(0, 0, 30); add(0, 1, 50); add(0, 2, 68); add(0, 3, 87);
        add(1, 0, 30); add(1, 1, 50); add(1, 2, 68); add(1, 3, 86); add(1, 3, 87);
        run_event("residual edge");

        // R7: five clusters in x plane 1
        for (int m = 10; m <= 40; m += 10) begin add_line(0, m); add_line(1, m); end
        add(0, 0, 700);
        run_event("overflow");

        // R6: y plane 3 empty
        for (int m = 10; m <= 40; m += 10) add_line(0, m);
        add(1, 0, 30); add(1, 1, 49); add(1, 3, 87);
        run_event("empty plane");

        // R4: parallel line far from axis misses the target window
        add(0, 0, 200); add(0, 1, 200); add(0, 2, 200); add(0, 3, 200);
        add_line(0, 20);
        add_line(1, 20);
        run_event("target window");

        // R11: hits only in y
        for (int m = 10; m <= 40; m += 10) add_line(1, m);
        run_event("y only");

        // random events mixing lines and noise
        for (int e = 0; e < 24; e++) begin
            int nl;
            nl = rnd(5);
            for (int i = 0; i < nl; i++) begin
                int m;
                m = 5 + rnd(45);
                add_line(rnd(2), m);
            end
            for (int i = 0; i < 8; i++) begin
                int n;
                n = (rnd(11) == 0) ? 6 : rnd(3);
                for (int j = 0; j < n; j++) hl[i].push_back(rnd(1024));
            end
            run_event($sformatf("random %0d", e));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule